// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, day of month, month, two-digit year and weekday. A one-cycle pulse on `tick`, arriving once per second, advances the calendar while the run bit is set. Month lengths are handled, and February has 29 days in years divisible by four. Software reaches the block through a byte-wide register bus with a 5-bit address, a write strobe, write data and combinational read data.

The block compares the live time against six programmable alarm fields. On a match it sets a sticky alarm flag. It also flags every second, minute, hour and day rollover, and it holds a power-up flag that reset sets. All of these flags are cleared by writing a one to them. The level interrupt output combines the enabled alarm flag with one enabled periodic flag, selected by a 2-bit period field. Software changes the time only while the clock is stopped. It reads the time from a snapshot copy, which a control strobe takes in a single cycle, so a multi-byte read never mixes two instants.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the live time and snapshot are 00:00:00, day 01, month 01, year 00, weekday 0. The alarm fields are 00, control reads 0x00, interrupt enable reads 0x00, status reads 0x80 (power-up flag, bit 7) and `irq` is low.
- R2: The calendar advances by one second on a `tick` pulse only while control bit 0 (run) is 1. While run is 0, ticks change neither time nor flags. Status bit 1 reads back the run bit.
- R3: Writes to addresses 0x00..0x06 (seconds, minutes, hours, day, month, year, weekday) load the live time only while run is 0. While run is 1 such writes are ignored.
- R4: Reads of 0x00..0x06 return the snapshot. Writing control (0x0D) with bit 6 set copies the live time into the snapshot at that edge. Bit 6 is a strobe and reads back 0.
- R5: Seconds and minutes wrap 59 to 00 and carry. Hours wrap 23 to 00 and carry into the day. The weekday counts 0..6 and advances with each day change.
- R6: The day wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the others, and for month 02 it is 29 when the year is divisible by 4 and 28 otherwise. The month wraps 12 to 01 and carries into the year, and the year wraps 99 to 00.
- R7: On a counted tick, status bit 2 is set. Bit 3 is set when the minute changes, bit 4 when the hour changes and bit 5 when the day changes.
- R8: Status bit 6 (alarm) is set by a counted tick after which seconds, minutes, hours, day, month and year all equal the alarm registers at 0x07..0x0C. The flag stays set until it is cleared.
- R9: A write to status (0x0E) clears each of bits 2..7 where the written data has a 1 and leaves bits with a 0 unchanged. A flag being set in the same cycle wins over its clear.
- R10: `irq` = (enable bit 3 AND alarm flag) OR (enable bit 2 AND the periodic flag selected by enable bits 1:0: 0 second, 1 minute, 2 hour, 3 day). Enable lives at 0x0F, and bits 3:0 read back.
- R11: Alarm registers read back at 0x07..0x0C. Addresses 0x10..0x1F read 0x00 and are not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | 5 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that software loads only valid packed BCD values that lie inside each field's range, and a day that exists in the month written. They also assume `tick` is a single-cycle pulse. The stepping and range properties rely on both. The random stimulus builds every start time from binary values within range, converted by a bench function. It loads that time only while the clock is stopped, and it drives each tick for exactly one cycle, followed by at least one idle cycle. Starting points are biased toward the last minutes of the last days of random months and years, so that the short runs of ticks cross month, leap-year and century-of-year boundaries.

// File: rtl/rtc_calendar.sv
module rtc_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [4:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);

  logic [7:0] tm   [7];
  logic [7:0] snap [7];
  logic [7:0] al   [6];
  logic [7:0] nx   [7];
  logic       run;
  logic [5:0] st;
  logic [3:0] ie;
  logic [6:0] ybin;
  logic [7:0] mlast;
  logic [4:0] aoff;
  logic       cs, cm, ch, cd, cmo, cy, hit;
  logic       wr_time, wr_alarm, wr_ctrl, wr_stat;
  logic [55:0] tbus;

  function automatic logic [7:0] bnext(input logic [7:0] v, input logic [7:0] last,
                                       input logic [7:0] first);
    if (v == last) return first;
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  assign aoff     = addr - 5'd7;
  assign wr_time  = wr_en && addr < 5'd7 && !run;
  assign wr_alarm = wr_en && addr >= 5'd7 && addr < 5'd13;
  assign wr_ctrl  = wr_en && addr == 5'd13;
  assign wr_stat  = wr_en && addr == 5'd14;
  assign tbus     = {tm[6], tm[5], tm[4], tm[3], tm[2], tm[1], tm[0]};
  assign ybin     = 7'(tm[5][7:4]) * 7'd10 + 7'(tm[5][3:0]);

  always_comb begin
    case (tm[4])
      8'h02:                      mlast = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlast = 8'h30;
      default:                    mlast = 8'h31;
    endcase
    cs  = tick && run;
    cm  = cs  && tm[0] == 8'h59;
    ch  = cm  && tm[1] == 8'h59;
    cd  = ch  && tm[2] == 8'h23;
    cmo = cd  && tm[3] == mlast;
    cy  = cmo && tm[4] == 8'h12;
    nx[0] = cs  ? bnext(tm[0], 8'h59, 8'h00) : tm[0];
    nx[1] = cm  ? bnext(tm[1], 8'h59, 8'h00) : tm[1];
    nx[2] = ch  ? bnext(tm[2], 8'h23, 8'h00) : tm[2];
    nx[3] = cd  ? bnext(tm[3], mlast, 8'h01) : tm[3];
    nx[4] = cmo ? bnext(tm[4], 8'h12, 8'h01) : tm[4];
    nx[5] = cy  ? bnext(tm[5], 8'h99, 8'h00) : tm[5];
    nx[6] = cd  ? bnext(tm[6], 8'h06, 8'h00) : tm[6];
    hit = cs && nx[0] == al[0] && nx[1] == al[1] && nx[2] == al[2] &&
          nx[3] == al[3] && nx[4] == al[4] && nx[5] == al[5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin
        tm[i]   <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
        snap[i] <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
      end
      for (int i = 0; i < 6; i++) al[i] <= 8'h00;
      run <= 1'b0;
      ie  <= 4'h0;
      st  <= 6'b100000;
    end else begin
      if (cs) begin
        for (int i = 0; i < 7; i++) tm[i] <= nx[i];
      end else if (wr_time) begin
        tm[addr[2:0]] <= wdata;
      end
      if (wr_alarm) al[aoff[2:0]] <= wdata;
      if (wr_ctrl) begin
        run <= wdata[0];
        if (wdata[6]) for (int i = 0; i < 7; i++) snap[i] <= tm[i];
      end
      if (wr_en && addr == 5'd15) ie <= wdata[3:0];
      st <= (st & ~(wr_stat ? wdata[7:2] : 6'b0)) | {1'b0, hit, cd, ch, cm, cs};
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr < 5'd7)        rdata = snap[addr[2:0]];
    else if (addr < 5'd13)  rdata = al[aoff[2:0]];
    else if (addr == 5'd13) rdata = {7'b0, run};
    else if (addr == 5'd14) rdata = {st, run, 1'b0};
    else if (addr == 5'd15) rdata = {4'b0, ie};
  end

  assign irq = (ie[3] && st[4]) || (ie[2] && st[ie[1:0]]);

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && addr < 5'd7)) |=> $stable(tbus));

  p_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(tbus));

  p_sec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && tm[0][3:0] != 4'h9) |=> tm[0] == $past(tm[0]) + 8'h01);

  p_sec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tm[0] <= 8'h59 && tm[0][3:0] <= 4'h9 && tm[1] <= 8'h59 && tm[2] <= 8'h23);

  p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st[4] && !(wr_stat && wdata[6])) |=> st[4]);

  p_irq_alarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st[4] && ie[3]) |-> irq);

endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [4:0] addr = 5'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int ms, mm, mh, md, mmo, my, mw;
  int mev;
  bit brun;

  rtc_calendar u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
                   .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] mpack();
    return {bcd(mw), bcd(my), bcd(mmo), bcd(md), bcd(mh), bcd(mm), bcd(ms)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 5'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = 5'(a);
    #1;
    d = rdata;
  endtask

  task automatic m_adv();
    ms++; mev |= 32'h04;
    if (ms == 60) begin
      ms = 0; mm++; mev |= 32'h08;
      if (mm == 60) begin
        mm = 0; mh++; mev |= 32'h10;
        if (mh == 24) begin
          mh = 0; mev |= 32'h20; mw = (mw + 1) % 7; md++;
          if (md > dim(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (brun) m_adv();
  endtask

  task automatic set_run(input bit r);
    brun = r;
    wr(13, r ? 1 : 0);
  endtask

  task automatic load_time();
    logic [55:0] p;
    p = mpack();
    set_run(0);
    for (int i = 0; i < 7; i++) wr(i, p[i*8 +: 8]);
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] b;
    wr(13, brun ? 8'h41 : 8'h40);
    for (int i = 0; i < 7; i++) begin rd(i, b); t[i*8 +: 8] = b; end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [55:0] t, tgt;
    int ss, sm, sh, sd, smo, sy, sw;
    void'($urandom(32'd2024));
    ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0; brun = 0; mev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(14, b); chk("R1 status", b, 8'h80);
    rd(13, b); chk("R1 ctrl", b, 8'h00);
    rd(15, b); chk("R1 ie", b, 8'h00);
    chk("R1 irq", irq, 1'b0);
    for (int i = 0; i < 7; i++) begin rd(i, b); t[i*8 +: 8] = b; end
    chk("R1 snapshot", t, mpack());
    rd(9, b); chk("R1 alarm hours", b, 8'h00);

    // R2 ticks ignored while stopped
    tk(); tk();
    read_time(t); chk("R2 stopped time", t, mpack());
    rd(14, b); chk("R2 stopped flags", b, 8'h80);

    // R3/R6 load leap-year Feb 28 23:59:58, weekday 6
    ms = 58; mm = 59; mh = 23; md = 28; mmo = 2; my = 24; mw = 6;
    load_time();
    read_time(t); chk("R3 load while stopped", t, mpack());
    rd(13, b); chk("R4 strobe reads 0", b, 8'h00);
    wr(14, 8'hFC);
    set_run(1);
    rd(14, b); chk("R2 run bit in status", b, 8'h02);
    tk(); mev = 0; tk();
    read_time(t); chk("R5 R6 leap day rollover", t, mpack());
    rd(14, b); chk("R7 all events", b, 8'h3E);

    // R3 write ignored while running
    wr(0, 8'h33); wr(2, 8'h11);
    read_time(t); chk("R3 write ignored running", t, mpack());

    // R4 snapshot holds after time moves
    tk();
    for (int i = 0; i < 7; i++) begin rd(i, b); tgt[i*8 +: 8] = b; end
    chk("R4 snapshot frozen", tgt, t);

    // R9 write one to clear
    wr(14, 8'h00); rd(14, b); chk("R9 zero write keeps", b, 8'h3E);
    wr(14, 8'h24); rd(14, b); chk("R9 partial clear", b, 8'h1A);
    wr(14, 8'hFC); rd(14, b); chk("R9 full clear", b, 8'h02);

    // R8 alarm three seconds ahead
    ss = ms; sm = mm; sh = mh; sd = md; smo = mmo; sy = my; sw = mw;
    m_adv(); m_adv(); m_adv();
    tgt = mpack();
    ms = ss; mm = sm; mh = sh; md = sd; mmo = smo; my = sy; mw = sw;
    for (int i = 0; i < 6; i++) wr(7 + i, tgt[i*8 +: 8]);
    rd(10, b); chk("R11 alarm readback", b, tgt[31:24]);
    rd(20, b); chk("R11 unused address", b, 8'h00);
    wr(15, 8'h08);
    tk(); tk();
    rd(14, b); chk("R8 no early alarm", b[6], 1'b0);
    chk("R10 irq low before alarm", irq, 1'b0);
    tk();
    rd(14, b); chk("R8 alarm set", b[6], 1'b1);
    chk("R10 irq on alarm", irq, 1'b1);
    tk();
    rd(14, b); chk("R8 alarm sticky", b[6], 1'b1);
    wr(14, 8'h40);
    rd(14, b); chk("R9 alarm clear", b[6], 1'b0);
    chk("R10 irq drops", irq, 1'b0);
    wr(10, 8'h00);

    // R10 periodic minute select
    ms = 58; mm = 10; load_time(); set_run(1);
    wr(15, 8'h05); wr(14, 8'hFC);
    tk(); chk("R10 second flag not selected", irq, 1'b0);
    tk(); chk("R10 minute irq", irq, 1'b1);
    wr(15, 8'h01); chk("R10 timer disabled", irq, 1'b0);
    wr(15, 8'h06); chk("R10 hour not flagged", irq, 1'b0);
    rd(15, b); chk("R10 ie readback", b, 8'h06);
    wr(15, 8'h00);

    // R6 year and month wrap
    ms = 59; mm = 59; mh = 23; md = 31; mmo = 12; my = 99; mw = 3;
    load_time(); set_run(1); tk();
    read_time(t); chk("R6 year wrap", t, mpack());
    ms = 59; mm = 59; mh = 23; md = 28; mmo = 2; my = 23; mw = 1;
    load_time(); set_run(1); tk();
    read_time(t); chk("R6 non-leap February", t, mpack());

    // R5 R6 R7 random runs near month ends
    for (int k = 0; k < 40; k++) begin
      int n;
      my = $urandom_range(99); mmo = $urandom_range(12, 1);
      md = dim(mmo, my) - $urandom_range(1);
      mh = $urandom_range(23, 22); mm = $urandom_range(59, 57);
      ms = $urandom_range(59); mw = $urandom_range(6);
      load_time(); set_run(1);
      wr(14, 8'hFC); mev = 0;
      n = $urandom_range(150, 1);
      for (int j = 0; j < n; j++) tk();
      read_time(t); chk("R5 R6 random calendar", t, mpack());
      rd(14, b); chk("R7 random events", b & 8'h3C, 8'(mev));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule